// File: doc/BRIEF.md
# Panel Power-Up Command Sequencer

This block brings a display driver chip from power-up to a lit panel without any processor help. It first holds the panel's reset line low for a set time, then lets the panel's internal analog circuits settle. It then walks through an initialization table and sends each entry over a four-wire serial link: chip select, data/command select, serial clock and serial data. When the table is finished it raises a done flag. A restart request returns it to the hardware reset phase at any time.

The table sits in a small byte-wide read-only memory outside the block. The block reads it through a combinational address/data pair. Each entry is a run of bytes: the command byte, then a parameter count, then a post-delay in units of `DLY_UNIT_CYC` clock cycles, then the parameters. The command value 0xFF ends the table. All timing figures are parameters counted in system clock cycles. The defaults match a 50 MHz clock: 100 µs of reset, 5 ms of settle, 120 ms of sleep-exit wait and a 1 ms delay unit.

Top module: `panel_init_seq`

## Requirements
- R1: After `rst_n` is released or `restart_i` is seen, `lcd_rst_n_o` stays low for at least `RST_LOW_CYC` cycles and then rises.
- R2: No serial clock edge occurs until at least `SETTLE_CYC` cycles after `lcd_rst_n_o` rises.
- R3: `lcd_cs_n_o` is low no later than the cycle in which `lcd_rst_n_o` rises. It stays low during every transferred bit and goes high once the sequence is done.
- R4: The serial link uses mode 0, MSB first. `lcd_sclk_o` idles low, the panel samples on its rising edge, and `lcd_mosi_o` and `lcd_dc_o` change only while `lcd_sclk_o` is low.
- R5: `lcd_dc_o` is 0 during every bit of a command byte and 1 during every bit of a parameter byte.
- R6: Each table entry is read as the bytes command, count, delay, then count parameters, starting at address 0. The link carries the command followed by exactly count parameters, in table order. A count of 0 sends only the command.
- R7: Bytes within one entry go out back to back. From the last rising clock edge of one byte to the first rising edge of the next is at most 2*`SCLK_HALF_DIV`+8 cycles.
- R8: After an entry's last byte, the next command starts at least delay*`DLY_UNIT_CYC` cycles later and at most 4*`SCLK_HALF_DIV`+16 cycles beyond that.
- R9: After an entry whose command is 0x11, the gap before the next command is at least `SLEEP_CYC` cycles, whatever the entry's own delay is.
- R10: When the command byte 0xFF is read, no further bytes are sent. `done_o` goes to 1 with `lcd_cs_n_o` high and `lcd_rst_n_o` high.
- R11: One cycle after `restart_i` is high, `lcd_rst_n_o` and `lcd_sclk_o` are 0 and `done_o` is 0, even in the middle of a byte. The full sequence then runs again from table address 0.
- R12: While `rst_n` is low, `lcd_rst_n_o`, `lcd_cs_n_o`, `lcd_sclk_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| restart_i | input | 1 | Request to abort and rerun from the reset phase |
| rom_addr_o | output | ROM_AW | Table byte address |
| rom_data_i | input | 8 | Table byte at `rom_addr_o`, same cycle |
| lcd_rst_n_o | output | 1 | Panel hardware reset, active low |
| lcd_cs_n_o | output | 1 | Panel chip select, active low |
| lcd_dc_o | output | 1 | 0 = command byte, 1 = parameter byte |
| lcd_sclk_o | output | 1 | Serial clock |
| lcd_mosi_o | output | 1 | Serial data to the panel |
| done_o | output | 1 | Sequence complete |

## Verification
The restart request and an active serial shift can fall in the same cycle, and so can the restart request and the done state. Both cases hinge on the abort winning cleanly over the byte in flight. The bench provokes the first case by watching its own decode of the serial clock and pulsing `restart_i` after the third bit of the fourth byte. It judges the result one cycle later at the pins, where reset must be low, the clock low and done low. It then requires a complete, correctly ordered replay with correct reset and settle spacing and no stray partial byte. The second case is provoked by restarting from the done state between the random tables, and is judged by the same full replay check.

// File: rtl/pis_pkg.sv
package pis_pkg;

    typedef enum logic [3:0] {
        ST_RST_LOAD,
        ST_RST_HOLD,
        ST_SETTLE,
        ST_RD_CMD,
        ST_RD_LEN,
        ST_RD_DLY,
        ST_SEND_CMD,
        ST_WAIT_CMD,
        ST_SEND_PAR,
        ST_WAIT_PAR,
        ST_DLY_LOAD,
        ST_DLY_WAIT,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] CMD_TABLE_END  = 8'hFF;
    localparam logic [7:0] CMD_SLEEP_EXIT = 8'h11;

endpackage

// File: rtl/pis_delay_timer.sv
module pis_delay_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] value_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pis_spi_tx.sv
module pis_spi_tx #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort_i,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    input  logic       dc_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       dc_o,
    output logic       done_o
);

    localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [7:0]    shr;
        logic [2:0]    bit_idx;
        logic [CW-1:0] cnt;
        logic          dc;
        logic          done;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.done = 1'b0;
        if (abort_i) begin
            // drop the byte in flight, park the clock low
            tx_d.busy    = 1'b0;
            tx_d.sclk    = 1'b0;
            tx_d.cnt     = '0;
            tx_d.bit_idx = '0;
        end else if (!tx_q.busy) begin
            if (start_i) begin
                tx_d.busy    = 1'b1;
                tx_d.sclk    = 1'b0;
                tx_d.shr     = byte_i;
                tx_d.dc      = dc_i;
                tx_d.cnt     = '0;
                tx_d.bit_idx = '0;
            end
        end else if (tx_q.cnt == CNT_LAST) begin
            tx_d.cnt = '0;
            if (!tx_q.sclk) begin
                tx_d.sclk = 1'b1;
            end else begin
                tx_d.sclk = 1'b0;
                if (tx_q.bit_idx == 3'd7) begin
                    tx_d.busy = 1'b0;
                    tx_d.done = 1'b1;
                end else begin
                    tx_d.bit_idx = tx_q.bit_idx + 3'd1;
                    tx_d.shr     = {tx_q.shr[6:0], 1'b0};
                end
            end
        end else begin
            tx_d.cnt = tx_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sclk_o = tx_q.sclk;
    assign mosi_o = tx_q.shr[7];
    assign dc_o   = tx_q.dc;
    assign done_o = tx_q.done;

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import pis_pkg::*;
#(
    parameter int unsigned RST_LOW_CYC   = 5000,
    parameter int unsigned SETTLE_CYC    = 250000,
    parameter int unsigned SLEEP_CYC     = 6000000,
    parameter int unsigned DLY_UNIT_CYC  = 50000,
    parameter int unsigned SCLK_HALF_DIV = 2,
    parameter int unsigned ROM_AW        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [7:0]        rom_data_i,
    output logic              lcd_rst_n_o,
    output logic              lcd_cs_n_o,
    output logic              lcd_dc_o,
    output logic              lcd_sclk_o,
    output logic              lcd_mosi_o,
    output logic              done_o
);

    localparam longint unsigned DLY_MAX = 64'(DLY_UNIT_CYC) * 64'd255;
    localparam longint unsigned MAX_A   = (64'(RST_LOW_CYC) > 64'(SETTLE_CYC)) ?
                                          64'(RST_LOW_CYC) : 64'(SETTLE_CYC);
    localparam longint unsigned MAX_B   = (64'(SLEEP_CYC) > DLY_MAX) ? 64'(SLEEP_CYC) : DLY_MAX;
    localparam longint unsigned MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned     TW      = $clog2(MAX_ALL + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ROM_AW-1:0] ptr;
        logic [7:0]        cmd;
        logic [7:0]        len;
        logic [7:0]        dly;
        logic              pnl_rst_n;
        logic              cs_n;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          tx_start;
    logic [7:0]    tx_byte;
    logic          tx_dc;
    logic          tx_abort;
    logic          tx_done;
    logic [TW-1:0] post_dly;

    // post-delay of the current entry, stretched after sleep exit
    always_comb begin
        post_dly = TW'(seq_q.dly) * TW'(DLY_UNIT_CYC);
        if (seq_q.cmd == CMD_SLEEP_EXIT && post_dly < TW'(SLEEP_CYC)) begin
            post_dly = TW'(SLEEP_CYC);
        end
    end

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tx_start = 1'b0;
        tx_byte  = seq_q.cmd;
        tx_dc    = 1'b0;
        tx_abort = 1'b0;

        if (restart_i) begin
            tx_abort        = 1'b1;
            seq_d.state     = ST_RST_LOAD;
            seq_d.ptr       = '0;
            seq_d.pnl_rst_n = 1'b0;
            seq_d.cs_n      = 1'b0;
            seq_d.done      = 1'b0;
        end else begin
            unique case (seq_q.state)
                ST_RST_LOAD: begin
                    tmr_load        = 1'b1;
                    tmr_val         = TW'(RST_LOW_CYC);
                    seq_d.pnl_rst_n = 1'b0;
                    seq_d.cs_n      = 1'b0;
                    seq_d.state     = ST_RST_HOLD;
                end
                ST_RST_HOLD: begin
                    if (tmr_zero) begin
                        tmr_load        = 1'b1;
                        tmr_val         = TW'(SETTLE_CYC);
                        seq_d.pnl_rst_n = 1'b1;
                        seq_d.state     = ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_zero) begin
                        seq_d.state = ST_RD_CMD;
                    end
                end
                ST_RD_CMD: begin
                    seq_d.cmd = rom_data_i;
                    seq_d.ptr = seq_q.ptr + ROM_AW'(1);
                    if (rom_data_i == CMD_TABLE_END) begin
                        seq_d.state = ST_DONE;
                        seq_d.cs_n  = 1'b1;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.state = ST_RD_LEN;
                    end
                end
                ST_RD_LEN: begin
                    seq_d.len   = rom_data_i;
                    seq_d.ptr   = seq_q.ptr + ROM_AW'(1);
                    seq_d.state = ST_RD_DLY;
                end
                ST_RD_DLY: begin
                    seq_d.dly   = rom_data_i;
                    seq_d.ptr   = seq_q.ptr + ROM_AW'(1);
                    seq_d.state = ST_SEND_CMD;
                end
                ST_SEND_CMD: begin
                    tx_start    = 1'b1;
                    tx_byte     = seq_q.cmd;
                    tx_dc       = 1'b0;
                    seq_d.state = ST_WAIT_CMD;
                end
                ST_WAIT_CMD, ST_WAIT_PAR: begin
                    if (tx_done) begin
                        seq_d.state = (seq_q.len == 8'd0) ? ST_DLY_LOAD : ST_SEND_PAR;
                    end
                end
                ST_SEND_PAR: begin
                    tx_start    = 1'b1;
                    tx_byte     = rom_data_i;
                    tx_dc       = 1'b1;
                    seq_d.ptr   = seq_q.ptr + ROM_AW'(1);
                    seq_d.len   = seq_q.len - 8'd1;
                    seq_d.state = ST_WAIT_PAR;
                end
                ST_DLY_LOAD: begin
                    tmr_load    = 1'b1;
                    tmr_val     = post_dly;
                    seq_d.state = ST_DLY_WAIT;
                end
                ST_DLY_WAIT: begin
                    if (tmr_zero) begin
                        seq_d.state = ST_RD_CMD;
                    end
                end
                ST_DONE: begin
                    seq_d.state = ST_DONE;
                end
                default: begin
                    seq_d.state = ST_RST_LOAD;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q           <= '0;
            seq_q.state     <= ST_RST_LOAD;
            seq_q.pnl_rst_n <= 1'b0;
            seq_q.cs_n      <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    pis_delay_timer #(
        .TW(TW)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .value_i(tmr_val),
        .zero_o (tmr_zero)
    );

    pis_spi_tx #(
        .HALF_DIV(SCLK_HALF_DIV)
    ) tx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort_i(tx_abort),
        .start_i(tx_start),
        .byte_i (tx_byte),
        .dc_i   (tx_dc),
        .sclk_o (lcd_sclk_o),
        .mosi_o (lcd_mosi_o),
        .dc_o   (lcd_dc_o),
        .done_o (tx_done)
    );

    assign rom_addr_o  = seq_q.ptr;
    assign lcd_rst_n_o = seq_q.pnl_rst_n;
    assign lcd_cs_n_o  = seq_q.cs_n;
    assign done_o      = seq_q.done;

endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
    parameter int unsigned RST_LOW_CYC = 5000,
    parameter int unsigned SETTLE_CYC  = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic restart_i,
    input logic lcd_rst_n_o,
    input logic lcd_cs_n_o,
    input logic lcd_dc_o,
    input logic lcd_sclk_o,
    input logic lcd_mosi_o,
    input logic done_o
);

    logic [31:0] low_cnt_q;
    logic [31:0] high_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q  <= '0;
            high_cnt_q <= '0;
        end else begin
            if (!lcd_rst_n_o) begin
                high_cnt_q <= '0;
                if (low_cnt_q != 32'hFFFF_FFFF) low_cnt_q <= low_cnt_q + 32'd1;
            end else begin
                low_cnt_q <= '0;
                if (high_cnt_q != 32'hFFFF_FFFF) high_cnt_q <= high_cnt_q + 32'd1;
            end
        end
    end

    assert_reset_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_rst_n_o) |-> (low_cnt_q >= 32'(RST_LOW_CYC)));

    assert_settle_before_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_sclk_o) |-> (lcd_rst_n_o && high_cnt_q >= 32'(SETTLE_CYC)));

    assert_select_before_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_rst_n_o) |-> !lcd_cs_n_o);

    assert_clock_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sclk_o |-> !lcd_cs_n_o);

    assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sclk_o |-> ($stable(lcd_mosi_o) && $stable(lcd_dc_o)));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lcd_cs_n_o && lcd_rst_n_o && !lcd_sclk_o));

    assert_restart_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!lcd_rst_n_o && !lcd_sclk_o && !done_o));

endmodule

bind panel_init_seq pis_checker #(
    .RST_LOW_CYC(RST_LOW_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart_i),
    .lcd_rst_n_o(lcd_rst_n_o),
    .lcd_cs_n_o (lcd_cs_n_o),
    .lcd_dc_o   (lcd_dc_o),
    .lcd_sclk_o (lcd_sclk_o),
    .lcd_mosi_o (lcd_mosi_o),
    .done_o     (done_o)
);

// File: tb/panel_init_seq_tb_top.sv
module panel_init_seq_tb_top;

    localparam int RST_C  = 50;
    localparam int SET_C  = 200;
    localparam int SLP_C  = 300;
    localparam int UNIT_C = 10;
    localparam int HALF_C = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic [7:0] rom_addr;
    logic [7:0] rom_data;
    logic       lcd_rst_n, lcd_cs_n, lcd_dc, lcd_sclk, lcd_mosi, done;

    logic [7:0] rom_mem [0:255];
    assign rom_data = rom_mem[rom_addr];

    always #10 clk = ~clk;

    panel_init_seq #(
        .RST_LOW_CYC  (RST_C),
        .SETTLE_CYC   (SET_C),
        .SLEEP_CYC    (SLP_C),
        .DLY_UNIT_CYC (UNIT_C),
        .SCLK_HALF_DIV(HALF_C),
        .ROM_AW       (8)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .rom_addr_o (rom_addr),
        .rom_data_i (rom_data),
        .lcd_rst_n_o(lcd_rst_n),
        .lcd_cs_n_o (lcd_cs_n),
        .lcd_dc_o   (lcd_dc),
        .lcd_sclk_o (lcd_sclk),
        .lcd_mosi_o (lcd_mosi),
        .done_o     (done)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    // expected stream and gap windows; kind 7 = in-entry, 8 = delay, 9 = sleep
    int exp_b[$], exp_dc[$], gmin[$], gmax[$], gkind[$];
    int cap_b[$], cap_dc[$], cap_first[$], cap_last[$];
    int tbl_ptr;
    int prev_dly;
    logic [7:0] par [0:15];

    // serial decoder, sampled on the falling clock edge
    int   bitcnt = 0, cur_first = 0, cur_dc = 0, dc_bad = 0, cs_bad = 0, rst_rise = 0;
    logic [7:0] cur_b = '0;
    logic prev_sclk = 1'b0, prev_rst = 1'b0;
    always @(negedge clk) begin
        if (!lcd_rst_n) begin
            bitcnt = 0;
        end else if (lcd_sclk && !prev_sclk) begin
            if (bitcnt == 0) begin
                cur_first = cyc;
                cur_dc = int'(lcd_dc);
            end else if (int'(lcd_dc) != cur_dc) begin
                dc_bad++;
            end
            if (lcd_cs_n) cs_bad++;
            cur_b = {cur_b[6:0], lcd_mosi};
            bitcnt++;
            if (bitcnt == 8) begin
                cap_b.push_back(int'(cur_b));
                cap_dc.push_back(cur_dc);
                cap_first.push_back(cur_first);
                cap_last.push_back(cyc);
                bitcnt = 0;
            end
        end
        if (lcd_rst_n && !prev_rst) rst_rise = cyc;
        prev_sclk = lcd_sclk;
        prev_rst = lcd_rst_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int delay_cycles(input int cmd, input int dly);
        int d = dly * UNIT_C;
        if (cmd == 8'h11 && d < SLP_C) d = SLP_C;
        return d;
    endfunction

    task automatic table_begin();
        exp_b.delete(); exp_dc.delete(); gmin.delete(); gmax.delete(); gkind.delete();
        tbl_ptr = 0;
        prev_dly = -1;
        for (int i = 0; i < 256; i++) rom_mem[i] = 8'hFF;
    endtask

    task automatic add_entry(input int cmd, input int n, input int dly);
        rom_mem[tbl_ptr]   = 8'(cmd);
        rom_mem[tbl_ptr+1] = 8'(n);
        rom_mem[tbl_ptr+2] = 8'(dly);
        tbl_ptr += 3;
        exp_b.push_back(cmd); exp_dc.push_back(0);
        if (prev_dly < 0) begin
            gmin.push_back(-1); gmax.push_back(-1); gkind.push_back(0);
        end else begin
            gmin.push_back(prev_dly); gmax.push_back(prev_dly + 4*HALF_C + 16);
            gkind.push_back((exp_b.size() > 1 && gkind.size() > 0 && prev_dly >= SLP_C) ? 9 : 8);
        end
        for (int k = 0; k < n; k++) begin
            rom_mem[tbl_ptr] = par[k];
            tbl_ptr++;
            exp_b.push_back(int'(par[k])); exp_dc.push_back(1);
            gmin.push_back(0); gmax.push_back(2*HALF_C + 8); gkind.push_back(7);
        end
        prev_dly = delay_cycles(cmd, dly);
    endtask

    task automatic clear_capture();
        cap_b.delete(); cap_dc.delete(); cap_first.delete(); cap_last.delete();
        dc_bad = 0; cs_bad = 0;
    endtask

    task automatic pulse_restart(output int start_cyc);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        start_cyc = cyc;
        clear_capture();
    endtask

    task automatic run_and_check(input string tag, input int start_cyc);
        int waited = 0;
        int bad_b = 0, bad_dc = 0, bad7 = 0, bad8 = 0, bad9 = 0;
        int n;
        while (!done && waited < 60000) begin
            @(negedge clk); waited++;
        end
        chk(done == 1'b1, "R10", {tag, " done reached"}, done, 1);
        chk(lcd_cs_n && lcd_rst_n && !lcd_sclk, "R10", {tag, " idle pins at done"},
            {lcd_cs_n, lcd_rst_n, lcd_sclk}, 3'b110);
        chk(rst_rise - start_cyc >= RST_C && rst_rise - start_cyc <= RST_C + 6, "R1",
            {tag, " reset low width"}, rst_rise - start_cyc, RST_C);
        n = cap_b.size();
        if (n > 0)
            chk(cap_first[0] - rst_rise >= SET_C, "R2", {tag, " settle"},
                cap_first[0] - rst_rise, SET_C);
        chk(n == exp_b.size(), "R6", {tag, " byte count"}, n, exp_b.size());
        for (int i = 0; i < n && i < exp_b.size(); i++) begin
            int g;
            if (cap_b[i] != exp_b[i]) bad_b++;
            if (cap_dc[i] != exp_dc[i]) bad_dc++;
            if (i > 0 && gmin[i] >= 0) begin
                g = cap_first[i] - cap_last[i-1];
                if (g < gmin[i] || g > gmax[i]) begin
                    if (gkind[i] == 7) bad7++;
                    else if (gkind[i] == 9) bad9++;
                    else bad8++;
                    $display("  gap at byte %0d: %0d not in [%0d,%0d]", i, g, gmin[i], gmax[i]);
                end
            end
        end
        chk(bad_b == 0, "R4", {tag, " bytes MSB first in order"}, bad_b, 0);
        chk(bad_dc == 0 && dc_bad == 0, "R5", {tag, " data/command line"}, bad_dc + dc_bad, 0);
        chk(cs_bad == 0, "R3", {tag, " select low while clocking"}, cs_bad, 0);
        chk(bad7 == 0, "R7", {tag, " back-to-back parameters"}, bad7, 0);
        chk(bad8 == 0, "R8", {tag, " entry post-delay"}, bad8, 0);
        chk(bad9 == 0, "R9", {tag, " sleep exit wait"}, bad9, 0);
        repeat (60) @(negedge clk);
        chk(cap_b.size() == n, "R10", {tag, " silent after end"}, cap_b.size(), n);
    endtask

    task automatic build_directed();
        table_begin();
        add_entry(8'h01, 0, 2);
        add_entry(8'h11, 0, 1);
        for (int k = 0; k < 15; k++) par[k] = 8'($urandom_range(0, 255));
        add_entry(8'hE0, 15, 0);
        par[0] = 8'h55;
        add_entry(8'h3A, 1, 3);
        add_entry(8'h29, 0, 0);
    endtask

    task automatic build_random();
        int ne = $urandom_range(2, 5);
        table_begin();
        for (int e = 0; e < ne; e++) begin
            int c = $urandom_range(0, 8'hFE);
            int n = $urandom_range(0, 6);
            if ($urandom_range(0, 3) == 0) c = 8'h11;
            for (int k = 0; k < n; k++) par[k] = 8'($urandom_range(0, 255));
            add_entry(c, n, $urandom_range(0, 3));
        end
        add_entry(8'h29, 0, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int start_cyc;
        void'($urandom(32'd20240607));
        build_directed();
        // R12: held in block reset
        repeat (5) @(negedge clk);
        chk({lcd_rst_n, lcd_cs_n, lcd_sclk, done} == 4'b0000, "R12", "reset pin state",
            {lcd_rst_n, lcd_cs_n, lcd_sclk, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        start_cyc = cyc;
        chk(!lcd_rst_n && !lcd_cs_n, "R3", "select low with reset", {lcd_rst_n, lcd_cs_n}, 0);
        run_and_check("directed", start_cyc);

        // R11: restart with a byte in flight
        pulse_restart(start_cyc);
        while (!(cap_b.size() >= 3 && bitcnt == 3)) @(negedge clk);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        chk(!lcd_rst_n && !lcd_sclk && !done, "R11", "abort mid byte",
            {lcd_rst_n, lcd_sclk, done}, 0);
        start_cyc = cyc;
        clear_capture();
        run_and_check("replay", start_cyc);

        // random tables, each started by a restart from the done state (R11)
        for (int t = 0; t < 4; t++) begin
            build_random();
            pulse_restart(start_cyc);
            chk(!done && !lcd_rst_n, "R11", "restart from done", {done, lcd_rst_n}, 0);
            run_and_check($sformatf("random%0d", t), start_cyc);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule